// File: doc/BRIEF.md
# Goertzel Recurrence Engine

This block runs the second-order Goertzel recurrence over a window of signed 16-bit samples, so that software can take the power of one frequency bin without running the loop. Software programs a signed fixed-point feedback coefficient, a window length, a downsampling factor and an input selection through a small register port, then sets a start bit. For every accepted sample the engine updates three 48-bit state words in a single clock. When the last sample of the window has been taken, the engine clears its busy flag and raises a done flag. The state words stay in readable result registers, and software forms the bin power from them.

The engine takes two sample channels, each with a data word and a valid strobe. It can also replace the sample data with a software-written debug word. All settings are captured when the window starts, so software may stage the next window's values only once the engine is idle. Other co-processors that share the register map or the sample channels have no effect on it.

Top module: `goertzel_engine`

## Requirements
- R1: After reset, busy and done are low, and every readable register (addresses 0 to 9) reads zero.
- R2: For each accepted sample x, with signed Q2.14 coefficient c (address 2, bits [15:0]), the engine computes z0 = x + floor(c*z1 / 2^14) - z2 and then updates z2 <= z1, z1 <= z0 and the z0 register <= z0, all in the clock that takes the sample.
- R3: The state words are 48 bits wide. A full-scale sine at the analysed bin over a 2048-sample window produces results equal to exact integer arithmetic, with no wrap.
- R4: Starting a window clears z0, z1 and z2 to zero in the clock after the start write.
- R5: Window length, downsampling factor, input selection, coefficient and debug word are captured at start. While busy, writes to addresses 1, 2 and 3 are ignored: the readback keeps its old value and the running window is unaffected.
- R6: The downsampling factor D is address 1 bits [23:16]. Within a window the engine accepts the 1st, (D+1)th, (2D+1)th ... valid strobe of the selected channel. D = 0 behaves as D = 1.
- R7: The window length N is address 1 bits [15:0], and N = 0 behaves as N = 1. On the clock edge that takes the Nth accepted sample, busy falls and done rises.
- R8: Input select is address 1 bits [25:24]. Bit 0 picks channel B instead of channel A for both the pacing strobe and the data. Bit 1 replaces the data with the debug word (address 3 bits [15:0]). Strobes on the unselected channel are ignored.
- R9: Writing address 0 with bit 0 set starts a window and clears done, but only while idle. The same write during a window is ignored.
- R10: Read map: address 0 = {done in bit 1, busy in bit 0}. Address 1 = settings readback. Addresses 2 and 3 = coefficient and debug word, sign-extended. Addresses 4 to 9 = low word then high word of z0, z1 and z2. A high word holds state bits 47:32, sign-extended to 32 bits. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register write address |
| regWrData | input | 32 | Register write data |
| regRdAddr | input | 4 | Register read address (combinational read) |
| regRdData | output | 32 | Register read data |
| sampleAData | input | 16 | Channel A signed sample |
| sampleAValid | input | 1 | Channel A sample strobe |
| sampleBData | input | 16 | Channel B signed sample |
| sampleBValid | input | 1 | Channel B sample strobe |
| busy | output | 1 | Window in progress |
| done | output | 1 | Last window completed |

## Verification
The bench checks for a start write during a running window that restarts the window or clears the state, which would show up as a busy flag that stays high too long. It checks for settings writes that leak into a window already running, which would show up as wrong results or a changed readback. Downsampling is driven with sparse strobes and with both zero factor and zero length, so that a counter that is off by one, or a zero that is not mapped to one, gives a wrong accepted-sample count. A full-scale resonant sine and negative debug data exercise arithmetic shift, sign extension of the high words and overflow of the state width.

// File: rtl/goertzel_pkg.sv
package goertzel_pkg;

  // register addresses
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_CFG   = 1;
  localparam int ADDR_COEFF = 2;
  localparam int ADDR_DEBUG = 3;
  localparam int ADDR_ZBASE = 4;

  // control to datapath strobes
  typedef struct packed {
    logic clearState;
    logic stepState;
  } dpStrobe_t;

endpackage

// File: rtl/goertzel_ctrl.sv
module goertzel_ctrl
  import goertzel_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int SAMPLE_W = 16,
  parameter int COEFF_W  = 16,
  parameter int LEN_W    = 16,
  parameter int DEC_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic                validA,
  input  logic                validB,
  output dpStrobe_t           strobe,
  output logic                busy,
  output logic                done,
  output logic [LEN_W-1:0]    progLen,
  output logic [DEC_W-1:0]    progDec,
  output logic [1:0]          progSel,
  output logic [COEFF_W-1:0]  progCoeff,
  output logic [SAMPLE_W-1:0] progDebug,
  output logic [1:0]          actSel,
  output logic [COEFF_W-1:0]  actCoeff,
  output logic [SAMPLE_W-1:0] actDebug
);

  localparam int DEC_LSB = LEN_W;
  localparam int SEL_LSB = LEN_W + DEC_W;

  logic [LEN_W-1:0] actLen, sampleCnt;
  logic [DEC_W-1:0] actDec, decCnt;
  logic             startReq, cfgWrOk, selValid, takeSample, lastSample;
  logic             unusedWr;

  assign unusedWr   = ^regWrData;
  assign startReq   = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL)) && regWrData[0] && !busy;
  assign cfgWrOk    = regWrEn && !busy;
  assign selValid   = actSel[0] ? validB : validA;
  assign takeSample = busy && selValid && (decCnt == '0);
  assign lastSample = takeSample && (sampleCnt == actLen - LEN_W'(1));

  assign strobe.clearState = startReq;
  assign strobe.stepState  = takeSample;

  // programmed settings, writable only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progLen   <= '0;
      progDec   <= '0;
      progSel   <= '0;
      progCoeff <= '0;
      progDebug <= '0;
    end else if (cfgWrOk) begin
      if (regAddr == ADDR_W'(ADDR_CFG)) begin
        progLen <= regWrData[LEN_W-1:0];
        progDec <= regWrData[DEC_LSB +: DEC_W];
        progSel <= regWrData[SEL_LSB +: 2];
      end
      if (regAddr == ADDR_W'(ADDR_COEFF)) progCoeff <= regWrData[COEFF_W-1:0];
      if (regAddr == ADDR_W'(ADDR_DEBUG)) progDebug <= regWrData[SAMPLE_W-1:0];
    end
  end

  // window sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      actLen    <= '0;
      actDec    <= '0;
      actSel    <= '0;
      actCoeff  <= '0;
      actDebug  <= '0;
      sampleCnt <= '0;
      decCnt    <= '0;
    end else if (startReq) begin
      busy      <= 1'b1;
      done      <= 1'b0;
      actLen    <= (progLen == '0) ? LEN_W'(1) : progLen;
      actDec    <= (progDec == '0) ? DEC_W'(1) : progDec;
      actSel    <= progSel;
      actCoeff  <= progCoeff;
      actDebug  <= progDebug;
      sampleCnt <= '0;
      decCnt    <= '0;
    end else if (busy && selValid) begin
      decCnt <= (decCnt == actDec - DEC_W'(1)) ? '0 : decCnt + DEC_W'(1);
      if (lastSample) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (takeSample) begin
        sampleCnt <= sampleCnt + LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/goertzel_datapath.sv
module goertzel_datapath
  import goertzel_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int COEFF_W    = 16,
  parameter int COEFF_FRAC = 14,
  parameter int STATE_W    = 48
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [1:0]                 actSel,
  input  logic signed [COEFF_W-1:0]  actCoeff,
  input  logic signed [SAMPLE_W-1:0] actDebug,
  input  logic signed [SAMPLE_W-1:0] sampleAData,
  input  logic signed [SAMPLE_W-1:0] sampleBData,
  output logic signed [SAMPLE_W-1:0] sampleSel,
  output logic signed [STATE_W-1:0]  z0,
  output logic signed [STATE_W-1:0]  z1,
  output logic signed [STATE_W-1:0]  z2
);

  localparam int PROD_W = STATE_W + COEFF_W;

  logic signed [PROD_W-1:0]  coeffWide, z1Wide, prodWide;
  logic signed [STATE_W-1:0] sampleWide, feedback, z0Next;
  logic                      unusedProd;

  always_comb begin
    if (actSel[1])      sampleSel = actDebug;
    else if (actSel[0]) sampleSel = sampleBData;
    else                sampleSel = sampleAData;
  end

  assign coeffWide  = PROD_W'(actCoeff);
  assign z1Wide     = PROD_W'(z1);
  assign prodWide   = coeffWide * z1Wide;
  assign feedback   = prodWide[COEFF_FRAC +: STATE_W];
  assign unusedProd = ^prodWide;
  assign sampleWide = STATE_W'(sampleSel);
  assign z0Next     = sampleWide + feedback - z2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      z0 <= '0;
      z1 <= '0;
      z2 <= '0;
    end else if (strobe.clearState) begin
      z0 <= '0;
      z1 <= '0;
      z2 <= '0;
    end else if (strobe.stepState) begin
      z0 <= z0Next;
      z1 <= z0Next;
      z2 <= z1;
    end
  end

endmodule

// File: rtl/goertzel_engine.sv
module goertzel_engine
  import goertzel_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int SAMPLE_W   = 16,
  parameter int COEFF_W    = 16,
  parameter int COEFF_FRAC = 14,
  parameter int STATE_W    = 48,
  parameter int LEN_W      = 16,
  parameter int DEC_W      = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [ADDR_W-1:0]   regRdAddr,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [SAMPLE_W-1:0] sampleAData,
  input  logic                sampleAValid,
  input  logic [SAMPLE_W-1:0] sampleBData,
  input  logic                sampleBValid,
  output logic                busy,
  output logic                done
);

  localparam int NUM_STATE = 3;
  localparam int RES_WORDS = 2 * NUM_STATE;

  dpStrobe_t                  dpStrobe;
  logic                       clearStb, stepStb;
  logic [LEN_W-1:0]           progLen;
  logic [DEC_W-1:0]           progDec;
  logic [1:0]                 progSel, actSel;
  logic [COEFF_W-1:0]         progCoeff, actCoeff;
  logic [SAMPLE_W-1:0]        progDebug, actDebug;
  logic signed [SAMPLE_W-1:0] sampleSel;
  logic signed [STATE_W-1:0]  z0, z1, z2;
  logic signed [STATE_W-1:0]  zState [NUM_STATE];
  logic [DATA_W-1:0]          resWord [RES_WORDS];

  assign clearStb = dpStrobe.clearState;
  assign stepStb  = dpStrobe.stepState;

  goertzel_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W),
    .COEFF_W(COEFF_W), .LEN_W(LEN_W), .DEC_W(DEC_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .validA(sampleAValid), .validB(sampleBValid),
    .strobe(dpStrobe), .busy(busy), .done(done),
    .progLen(progLen), .progDec(progDec), .progSel(progSel),
    .progCoeff(progCoeff), .progDebug(progDebug),
    .actSel(actSel), .actCoeff(actCoeff), .actDebug(actDebug)
  );

  goertzel_datapath #(
    .SAMPLE_W(SAMPLE_W), .COEFF_W(COEFF_W),
    .COEFF_FRAC(COEFF_FRAC), .STATE_W(STATE_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(dpStrobe), .actSel(actSel),
    .actCoeff(actCoeff), .actDebug(actDebug),
    .sampleAData(sampleAData), .sampleBData(sampleBData),
    .sampleSel(sampleSel), .z0(z0), .z1(z1), .z2(z2)
  );

  assign zState[0] = z0;
  assign zState[1] = z1;
  assign zState[2] = z2;

  // each state word split into a low word and a sign-extended high word
  for (genvar g = 0; g < NUM_STATE; g++) begin : gResult
    assign resWord[2*g]   = zState[g][DATA_W-1:0];
    assign resWord[2*g+1] = DATA_W'(zState[g] >>> DATA_W);
  end

  always_comb begin
    regRdData = '0;
    if (regRdAddr == ADDR_W'(ADDR_CTRL))  regRdData = DATA_W'({done, busy});
    if (regRdAddr == ADDR_W'(ADDR_CFG))   regRdData = DATA_W'({progSel, progDec, progLen});
    if (regRdAddr == ADDR_W'(ADDR_COEFF)) regRdData = DATA_W'($signed(progCoeff));
    if (regRdAddr == ADDR_W'(ADDR_DEBUG)) regRdData = DATA_W'($signed(progDebug));
    for (int i = 0; i < RES_WORDS; i++) begin
      if (regRdAddr == ADDR_W'(ADDR_ZBASE + i)) regRdData = resWord[i];
    end
  end

endmodule

// File: rtl/goertzel_engine_chk.sv
module goertzel_engine_chk #(
  parameter int SAMPLE_W   = 16,
  parameter int COEFF_W    = 16,
  parameter int COEFF_FRAC = 14,
  parameter int STATE_W    = 48
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       clearStb,
  input logic                       stepStb,
  input logic                       busy,
  input logic                       done,
  input logic [1:0]                 actSel,
  input logic signed [COEFF_W-1:0]  actCoeff,
  input logic signed [SAMPLE_W-1:0] sampleSel,
  input logic signed [STATE_W-1:0]  z0,
  input logic signed [STATE_W-1:0]  z1,
  input logic signed [STATE_W-1:0]  z2
);

  localparam int WIDE_W = STATE_W + COEFF_W + 2;

  logic signed [WIDE_W-1:0] wideNext;

  // exact-width recurrence used to detect wrap of the state width
  always_comb begin
    wideNext = WIDE_W'(sampleSel)
             + ((WIDE_W'(actCoeff) * WIDE_W'(z1)) >>> COEFF_FRAC)
             - WIDE_W'(z2);
  end

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rstN)
    stepStb |=> (z2 == $past(z1)) && (z1 == z0));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    stepStb |=> (WIDE_W'(z0) == $past(wideNext)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    clearStb |=> (z0 == '0) && (z1 == '0) && (z2 == '0));

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(actCoeff) && $stable(actSel)));

  assert_step_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    stepStb |-> busy);

  assert_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $rose(done));

  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    clearStb |=> busy && !done);

endmodule

bind goertzel_engine goertzel_engine_chk #(
  .SAMPLE_W(SAMPLE_W), .COEFF_W(COEFF_W),
  .COEFF_FRAC(COEFF_FRAC), .STATE_W(STATE_W)
) uChk (
  .clk(clk), .rstN(rstN), .clearStb(clearStb), .stepStb(stepStb),
  .busy(busy), .done(done), .actSel(actSel), .actCoeff(actCoeff),
  .sampleSel(sampleSel), .z0(z0), .z1(z1), .z2(z2)
);

// File: tb/tb_goertzel_engine.sv
module tb_goertzel_engine;

  localparam int CLK_PERIOD = 10;
  localparam real PI = 3.14159265358979;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [3:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic [15:0] sAData = '0, sBData = '0;
  logic        sAValid = 1'b0, sBValid = 1'b0;
  logic        busy, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  goertzel_engine dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .sampleAData(sAData), .sampleAValid(sAValid),
    .sampleBData(sBData), .sampleBValid(sBValid),
    .busy(busy), .done(done)
  );

  int nCompared = 0;
  int nMismatch = 0;
  bit finished  = 1'b0;

  // behavioural reference model
  logic [15:0] pLen = '0, pCoeff = '0, pDebug = '0;
  logic [7:0]  pDec = '0;
  logic [1:0]  pSel = '0, aSel = '0;
  int          aLen = 0, aDec = 1, aCnt = 0, aDecCnt = 0;
  longint      aCoeff = 0, aDebug = 0, m0 = 0, m1 = 0, m2 = 0;
  bit          mBusy = 1'b0, mDone = 1'b0;

  always @(posedge clk or negedge rstN) begin
    bit     wasBusy, v;
    longint x, zn;
    if (!rstN) begin
      pLen = '0; pDec = '0; pSel = '0; pCoeff = '0; pDebug = '0;
      mBusy = 0; mDone = 0; m0 = 0; m1 = 0; m2 = 0;
    end else begin
      wasBusy = mBusy;
      v = aSel[0] ? sBValid : sAValid;
      if (wasBusy && v) begin
        if (aDecCnt == 0) begin
          if (aSel[1])      x = aDebug;
          else if (aSel[0]) x = longint'($signed(sBData));
          else              x = longint'($signed(sAData));
          zn = x + ((aCoeff * m1) >>> 14) - m2;
          m2 = m1; m1 = zn; m0 = zn;
          aCnt++;
          if (aCnt == aLen) begin mBusy = 0; mDone = 1; end
        end
        aDecCnt = (aDecCnt + 1) % aDec;
      end
      if (regWrEn && !wasBusy) begin
        case (regAddr)
          4'd0: if (regWrData[0]) begin
            mBusy = 1; mDone = 0;
            aLen = (pLen == 0) ? 1 : int'(pLen);
            aDec = (pDec == 0) ? 1 : int'(pDec);
            aSel = pSel;
            aCoeff = longint'($signed(pCoeff));
            aDebug = longint'($signed(pDebug));
            aCnt = 0; aDecCnt = 0; m0 = 0; m1 = 0; m2 = 0;
          end
          4'd1: {pSel, pDec, pLen} = regWrData[25:0];
          4'd2: pCoeff = regWrData[15:0];
          4'd3: pDebug = regWrData[15:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] expRead(int a);
    case (a)
      0: return {30'b0, mDone, mBusy};
      1: return 32'({pSel, pDec, pLen});
      2: return 32'($signed(pCoeff));
      3: return 32'($signed(pDebug));
      4: return m0[31:0];
      5: return m0[63:32];
      6: return m1[31:0];
      7: return m1[63:32];
      8: return m2[31:0];
      9: return m2[63:32];
      default: return 32'b0;
    endcase
  endfunction

  function automatic int rnd(real r);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // busy and done compared against the model on every clock (R7)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R7", "busy", 64'(busy), 64'(mBusy));
      check("R7", "done", 64'(done), 64'(mDone));
    end
  end

  task automatic cyc(bit we, int a, logic [31:0] d, bit va, logic [15:0] da, bit vb, logic [15:0] db);
    regWrEn = we; regAddr = 4'(a); regWrData = d;
    sAValid = va; sAData = da; sBValid = vb; sBData = db;
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 16'h0, 1'b0, 16'h0);
  endtask

  task automatic readCheck(string tag, int a);
    regRdAddr = 4'(a);
    #1;
    check(tag, $sformatf("read addr %0d", a), 64'(regRdData), 64'(expRead(a)));
  endtask

  task automatic checkAll(string tag);
    for (int a = 0; a < 11; a++) readCheck(tag, a);
  endtask

  task automatic runWindow(int aEvery, int bEvery);
    int c = 0;
    while (mBusy && c < 20000) begin
      cyc(1'b0, 0, 32'h0, (c % aEvery) == 0, 16'($urandom), (c % bEvery) == 0, 16'($urandom));
      c++;
    end
  endtask

  function automatic logic [31:0] cfgWord(int len, int dec, int sel);
    return {6'b0, 2'(sel), 8'(dec), 16'(len)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nMismatch++;
      $display("FAIL watchdog: actual hung expected completion");
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checkAll("R1");
    check("R1", "busy after reset", 64'(busy), 64'h0);

    // R2 / R10: basic window on channel A, coefficient for bin 3 of 40
    wr(2, 32'(rnd(2.0 * $cos(2.0 * PI * 3.0 / 40.0) * 16384.0)));
    wr(1, cfgWord(40, 1, 0));
    wr(0, 32'h1);
    // R4: start clears state
    readCheck("R4", 4); readCheck("R4", 6); readCheck("R4", 8);
    runWindow(1, 1);
    checkAll("R2");
    readCheck("R10", 5); readCheck("R10", 7); readCheck("R10", 9);

    // R6 / R8: channel B, downsample by 3, sparse B strobes, busy A
    wr(1, cfgWord(10, 3, 1));
    wr(0, 32'h1);
    runWindow(1, 2);
    checkAll("R6");
    readCheck("R8", 4);

    // R6 / R7: zero factor and zero length behave as one
    wr(1, cfgWord(0, 0, 0));
    wr(0, 32'h1);
    runWindow(3, 1);
    checkAll("R7");

    // R8: debug word replaces data, negative coefficient
    wr(3, 32'h0000FB2E);
    wr(2, 32'hFFFFA000);
    wr(1, cfgWord(8, 2, 2));
    wr(0, 32'h1);
    runWindow(1, 1);
    checkAll("R8");

    // R5 / R9: writes and a restart during a running window
    wr(2, 32'h00002000);
    wr(1, cfgWord(30, 1, 0));
    wr(0, 32'h1);
    for (int i = 0; i < 5; i++) cyc(1'b0, 0, 32'h0, 1'b1, 16'($urandom), 1'b0, 16'h0);
    cyc(1'b1, 2, 32'h00007000, 1'b1, 16'($urandom), 1'b0, 16'h0);
    cyc(1'b1, 1, cfgWord(3, 4, 3), 1'b1, 16'($urandom), 1'b0, 16'h0);
    cyc(1'b1, 3, 32'h00001111, 1'b1, 16'($urandom), 1'b0, 16'h0);
    cyc(1'b1, 0, 32'h1, 1'b1, 16'($urandom), 1'b0, 16'h0);
    checkAll("R5");
    readCheck("R9", 0);
    runWindow(1, 1);
    checkAll("R5");
    wr(0, 32'h1);
    readCheck("R9", 0);
    runWindow(1, 1);
    readCheck("R9", 0);

    // R3: full-scale resonant sine over 2048 samples
    wr(2, 32'(rnd(2.0 * $cos(2.0 * PI * 5.0 / 2048.0) * 16384.0)));
    wr(1, cfgWord(2048, 1, 0));
    wr(0, 32'h1);
    for (int n = 0; n < 2048; n++)
      cyc(1'b0, 0, 32'h0, 1'b1, 16'(rnd(32767.0 * $sin(2.0 * PI * 5.0 * n / 2048.0))), 1'b0, 16'h0);
    checkAll("R3");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

endmodule